// File: doc/BRIEF.md
# Programmable Third-Order Decimating Bitstream Filter

This block turns the single-bit output of an oversampling modulator into signed parallel words. Each incoming bit is treated as +1 or -1 and passed through three running-sum (integrator) stages. These run at the modulator strobe rate. At the decimated rate, three difference (comb) stages follow, so the frequency response is sinc cubed. The decimation ratio comes from a 12-bit rate code. A new code moves the notches of the response but leaves its shape unchanged.

The rate code is captured at reset and on every restart pulse. A restart is issued on a channel switch or after calibration. It also wipes the filter history and holds off the result words until the filter window holds only fresh samples. Each result is compared against a full-scale value derived from the ratio. Results in the small headroom region above full scale pass through with a warning flag. Results beyond the headroom are saturated and flagged. A data-ready flag tells a reader that a fresh word is waiting, and an acknowledge pulse clears it.

Top module: `sinc3_decimator`

## Requirements
- R1: Input bit 1 counts as +1 and bit 0 as -1. Consider a settled input repeating with period P, where P divides the ratio N and the pattern has K ones in each period. Each result word then equals N^3 * (2K - P) / P, before limiting.
- R2: The effective ratio N is the rate code when the code is 19 or more, and 19 otherwise. After the first result, exactly N input strobes separate consecutive results.
- R3: After reset or a restart pulse, the filter history is cleared. The first result appears on exactly the 4*N-th input strobe, counted from the restart. No result appears in the cycle after a restart.
- R4: Full scale is FS = floor(N^3 * 62415 / 65536). The limit is LIM = FS + floor(FS * 3277 / 65536), about 5 % of headroom. Result words are saturated to the range -LIM to +LIM.
- R5: With each result, the overrange flag is set exactly when the unlimited value's magnitude exceeds FS. This covers both saturated results and results inside the headroom.
- R6: Data-ready rises together with each result strobe and stays high until an acknowledge pulse. An acknowledge without a new result clears it on the next edge. Reset and restart clear it.
- R7: The result strobe lasts one cycle. The result word and the flag hold their values until the next result.
- R8: A rate code change without a restart has no effect on the ratio in use.
- R9: Reset drives the result word, result strobe, data-ready and overrange flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the rate code |
| bit_vld | input | 1 | Strobe: one modulator bit is present |
| bit_in | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| rate_code | input | 12 | Requested decimation ratio |
| restart | input | 1 | One-cycle pulse: capture the rate code, clear history, re-arm settling |
| rd_ack | input | 1 | One-cycle pulse: the reader has taken the current word |
| out_word | output | 37 | Signed result word, saturated to the limit |
| out_vld | output | 1 | One-cycle strobe: a new result word is present |
| data_rdy | output | 1 | A result is waiting for the reader |
| ovr | output | 1 | The current result exceeded full scale |

## Verification
The assertions are checked on every cycle:
- the ratio stays inside its legal range and stays fixed between restarts;
- the phase counter stays below the ratio;
- no result appears right after a restart;
- every result lies inside the limit;
- the overrange flag agrees with the magnitude of the word;
- the strobe is a single pulse and the word holds between results;
- an acknowledge clears data-ready.

Only the bench scenarios can show that the words match N^3 times the pattern mean, that the settling delay is exactly four periods, and that the spacing follows the clamped code. They also show that a restart discards old history and that an unrestarted code change is ignored.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  // Fixed-point constants for the full-scale and headroom thresholds.
  localparam int unsigned FRAC_SH   = 16;
  localparam int unsigned FS_MULT   = 62415; // 65536 / 1.05, rounded
  localparam int unsigned HEAD_MULT = 3277;  // 65536 * 0.05, rounded

  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_HIGH = 2'd1,
    CLIP_LOW  = 2'd2
  } clip_e;
endpackage

// File: rtl/sinc3_rate_cfg.sv
module sinc3_rate_cfg
  import sinc3_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int MIN_RATIO = 19,
  parameter int ACC_W     = 37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [CODE_W-1:0] rate_code,
  output logic [CODE_W-1:0] ratio,
  output logic [ACC_W-1:0]  full_scale,
  output logic [ACC_W-1:0]  limit
);
  localparam int PROD_W = ACC_W + FRAC_SH;
  localparam int SQ_W   = 2 * CODE_W;

  logic [CODE_W-1:0] eff_ratio;
  logic [CODE_W-1:0] ratio_q;
  logic [SQ_W-1:0]   sq_q;
  logic [ACC_W-1:0]  cube_q;
  logic [ACC_W-1:0]  fs_q;
  logic [ACC_W-1:0]  lim_q;
  logic [PROD_W-1:0] fs_prod;
  logic [PROD_W-1:0] head_prod;

  always_comb begin
    eff_ratio = (rate_code < CODE_W'(MIN_RATIO)) ? CODE_W'(MIN_RATIO) : rate_code;
    fs_prod   = PROD_W'(cube_q) * PROD_W'(FS_MULT);
    head_prod = PROD_W'(fs_q) * PROD_W'(HEAD_MULT);
  end

  // Ratio is latched only at reset or restart; thresholds follow it through
  // a free-running multiply pipeline that settles within four cycles.
  always_ff @(posedge clk) begin
    if (rst || restart) ratio_q <= eff_ratio;
    if (rst) begin
      sq_q   <= '0;
      cube_q <= '0;
      fs_q   <= '0;
      lim_q  <= '0;
    end else begin
      sq_q   <= {{CODE_W{1'b0}}, ratio_q} * {{CODE_W{1'b0}}, ratio_q};
      cube_q <= ACC_W'(sq_q) * ACC_W'(ratio_q);
      fs_q   <= ACC_W'(fs_prod >> FRAC_SH);
      lim_q  <= fs_q + ACC_W'(head_prod >> FRAC_SH);
    end
  end

  assign ratio      = ratio_q;
  assign full_scale = fs_q;
  assign limit      = lim_q;

  assert_ratio_floor_R2: assert property (@(posedge clk) disable iff (rst)
    ratio_q >= CODE_W'(MIN_RATIO));

  assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !restart |=> $stable(ratio_q));
endmodule

// File: rtl/sinc3_front.sv
module sinc3_front #(
  parameter int CODE_W = 12,
  parameter int ORDER  = 3,
  parameter int ACC_W  = 37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              bit_in,
  input  logic [CODE_W-1:0] ratio,
  output logic [ACC_W-1:0]  integ_out,
  output logic              tick
);
  logic [ACC_W-1:0]  acc [ORDER];
  logic [ACC_W-1:0]  step;
  logic [CODE_W-1:0] phase;

  // +1 for a one, -1 (all ones) for a zero; wrap-around arithmetic.
  assign step = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < ORDER; k++) acc[k] <= '0;
    end else if (en) begin
      acc[0] <= acc[0] + step;
      for (int k = 1; k < ORDER; k++) acc[k] <= acc[k] + acc[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (en) begin
        if (phase == ratio - CODE_W'(1)) begin
          phase <= '0;
          tick  <= 1'b1;
        end else begin
          phase <= phase + CODE_W'(1);
        end
      end
    end
  end

  assign integ_out = acc[ORDER-1];

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    phase < ratio);
endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs #(
  parameter int ORDER = 3,
  parameter int ACC_W = 37
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [ACC_W-1:0] integ_in,
  output logic [ACC_W-1:0] comb_out,
  output logic             comb_vld
);
  logic [ACC_W-1:0] chain [ORDER+1];
  logic [ACC_W-1:0] dly   [ORDER];

  assign chain[0] = integ_in;

  for (genvar g = 0; g < ORDER; g++) begin : g_diff
    assign chain[g+1] = chain[g] - dly[g];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < ORDER; k++) dly[k] <= '0;
      comb_out <= '0;
      comb_vld <= 1'b0;
    end else begin
      comb_vld <= tick;
      if (tick) begin
        for (int k = 0; k < ORDER; k++) dly[k] <= chain[k];
        comb_out <= chain[ORDER];
      end
    end
  end
endmodule

// File: rtl/sinc3_out_stage.sv
module sinc3_out_stage
  import sinc3_pkg::*;
#(
  parameter int ACC_W  = 37,
  parameter int SETTLE = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    comb_vld,
  input  logic [ACC_W-1:0]        comb_in,
  input  logic [ACC_W-1:0]        full_scale,
  input  logic [ACC_W-1:0]        limit,
  input  logic                    rd_ack,
  output logic signed [ACC_W-1:0] out_word,
  output logic                    out_vld,
  output logic                    data_rdy,
  output logic                    ovr
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0]        settle_cnt;
  logic signed [ACC_W-1:0] s_in;
  logic signed [ACC_W-1:0] lim_s;
  logic [ACC_W-1:0]        mag;
  logic                    over_fs;
  logic                    emit;
  clip_e                   clip;
  logic signed [ACC_W-1:0] clipped;

  always_comb begin
    s_in    = signed'(comb_in);
    lim_s   = signed'(limit);
    mag     = s_in[ACC_W-1] ? ACC_W'(-s_in) : ACC_W'(s_in);
    over_fs = mag > full_scale;
    if (s_in > lim_s)       clip = CLIP_HIGH;
    else if (s_in < -lim_s) clip = CLIP_LOW;
    else                    clip = CLIP_NONE;
    case (clip)
      CLIP_HIGH: clipped = lim_s;
      CLIP_LOW:  clipped = -lim_s;
      default:   clipped = s_in;
    endcase
    emit = comb_vld && (settle_cnt == CNT_W'(SETTLE - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      settle_cnt <= '0;
      out_word   <= '0;
      out_vld    <= 1'b0;
      data_rdy   <= 1'b0;
      ovr        <= 1'b0;
    end else begin
      out_vld <= emit;
      if (comb_vld && !emit) settle_cnt <= settle_cnt + CNT_W'(1);
      if (emit) begin
        out_word <= clipped;
        ovr      <= over_fs;
      end
      if (emit)        data_rdy <= 1'b1;
      else if (rd_ack) data_rdy <= 1'b0;
    end
  end

  logic [ACC_W-1:0] out_mag;
  assign out_mag = out_word[ACC_W-1] ? ACC_W'(-out_word) : ACC_W'(out_word);

  assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_vld);

  assert_within_limit_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_mag <= limit));

  assert_flag_matches_R5: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (ovr == (out_mag > full_scale)));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !comb_vld) |=> !data_rdy);

  assert_valid_ready_R6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> data_rdy);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!comb_vld && !clr) |=> ($stable(out_word) && $stable(ovr)));
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
  parameter int CODE_W    = 12,
  parameter int ORDER     = 3,
  parameter int MIN_RATIO = 19,
  parameter int SETTLE    = ORDER + 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bit_vld,
  input  logic                              bit_in,
  input  logic [CODE_W-1:0]                 rate_code,
  input  logic                              restart,
  input  logic                              rd_ack,
  output logic signed [ORDER*CODE_W:0]      out_word,
  output logic                              out_vld,
  output logic                              data_rdy,
  output logic                              ovr
);
  localparam int ACC_W = ORDER * CODE_W + 1;

  logic [CODE_W-1:0] ratio;
  logic [ACC_W-1:0]  full_scale;
  logic [ACC_W-1:0]  limit;
  logic [ACC_W-1:0]  integ_out;
  logic              tick;
  logic [ACC_W-1:0]  comb_out;
  logic              comb_vld;

  sinc3_rate_cfg #(
    .CODE_W(CODE_W), .MIN_RATIO(MIN_RATIO), .ACC_W(ACC_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .restart(restart), .rate_code(rate_code),
    .ratio(ratio), .full_scale(full_scale), .limit(limit)
  );

  sinc3_front #(
    .CODE_W(CODE_W), .ORDER(ORDER), .ACC_W(ACC_W)
  ) u_front (
    .clk(clk), .rst(rst), .clr(restart), .en(bit_vld), .bit_in(bit_in),
    .ratio(ratio), .integ_out(integ_out), .tick(tick)
  );

  sinc3_combs #(
    .ORDER(ORDER), .ACC_W(ACC_W)
  ) u_combs (
    .clk(clk), .rst(rst), .clr(restart), .tick(tick), .integ_in(integ_out),
    .comb_out(comb_out), .comb_vld(comb_vld)
  );

  sinc3_out_stage #(
    .ACC_W(ACC_W), .SETTLE(SETTLE)
  ) u_out (
    .clk(clk), .rst(rst), .clr(restart), .comb_vld(comb_vld),
    .comb_in(comb_out), .full_scale(full_scale), .limit(limit),
    .rd_ack(rd_ack), .out_word(out_word), .out_vld(out_vld),
    .data_rdy(data_rdy), .ovr(ovr)
  );
endmodule

// File: tb/sinc3_decimator_test.sv
module sinc3_decimator_test;
  localparam int CODE_W = 12;
  localparam int ACC_W  = 37;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst = 1'b1;
  logic                    bit_vld = 1'b0;
  logic                    bit_in = 1'b0;
  logic [CODE_W-1:0]       rate_code = 12'd20;
  logic                    restart = 1'b0;
  logic                    rd_ack = 1'b0;
  logic signed [ACC_W-1:0] out_word;
  logic                    out_vld;
  logic                    data_rdy;
  logic                    ovr;

  sinc3_decimator uut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .rate_code(rate_code), .restart(restart), .rd_ack(rd_ack),
    .out_word(out_word), .out_vld(out_vld), .data_rdy(data_rdy), .ovr(ovr)
  );

  typedef struct {
    longint val;
    bit     flag;
    int     gap;
  } exp_t;

  exp_t expq[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // R2: codes below 19 use 19.
  function automatic longint eff_ratio(int code);
    return (code < 19) ? 19 : code;
  endfunction

  // Driver: computes expectations from the requirements, queues them, drives stimulus.
  task automatic run(int code, logic [63:0] pat, int plen, int nout, bit poke_code);
    longint n, cube, fs, lim, c, v;
    int ones;
    bit fl;
    n = eff_ratio(code);
    cube = n * n * n;
    ones = 0;
    for (int i = 0; i < plen; i++) if (pat[i]) ones++;
    c = cube * longint'(2 * ones - plen) / longint'(plen);   // R1
    fs = (cube * 62415) >>> 16;                               // R4
    lim = fs + ((fs * 3277) >>> 16);
    v = (c > lim) ? lim : ((c < -lim) ? -lim : c);
    fl = (c > fs) || (c < -fs);                               // R5
    for (int k = 0; k < nout; k++) begin
      exp_t e;
      e.val = v;
      e.flag = fl;
      e.gap = (k == 0) ? int'(4 * n) : int'(n);               // R3 / R2
      expq.push_back(e);
    end
    rate_code = CODE_W'(code);
    step();
    restart = 1'b1;
    step();
    restart = 1'b0;
    chk(data_rdy == 1'b0, "R6", "data_rdy after restart", longint'(data_rdy), 0);
    chk(out_vld == 1'b0, "R3", "out_vld after restart", longint'(out_vld), 0);
    repeat (10) step();
    if (poke_code) rate_code = 12'd7;                         // R8: ignored without restart
    for (int j = 0; j < (3 + nout) * int'(n); j++) begin
      bit_in = pat[j % plen];
      bit_vld = 1'b1;
      step();
      bit_vld = 1'b0;
      repeat (3) step();
    end
    repeat (12) step();
    chk(expq.size() == 0, "R3", "results missing", longint'(expq.size()), 0);
    expq.delete();
  endtask

  // Monitor: counts strobes, pops and compares on each result.
  int  strobes = 0;
  bit  prev_vld = 1'b0;
  bit  hold_chk = 1'b0;
  longint last_word = 0;
  bit  last_flag = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (hold_chk) begin
        chk(!out_vld, "R7", "strobe width", longint'(out_vld), 0);
        chk(longint'(out_word) == last_word, "R7", "word hold", longint'(out_word), last_word);
        chk(ovr == last_flag, "R7", "flag hold", longint'(ovr), longint'(last_flag));
        hold_chk = 1'b0;
      end
      if (restart) strobes = 0;
      if (bit_vld) strobes++;
      if (out_vld) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected result", longint'(out_word), 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(longint'(out_word) == e.val, "R1", "result word", longint'(out_word), e.val);
          chk(ovr == e.flag, "R5", "overrange flag", longint'(ovr), longint'(e.flag));
          chk(strobes == e.gap, "R2", "strobes per result", longint'(strobes), longint'(e.gap));
          chk(data_rdy == 1'b1, "R6", "data_rdy with result", longint'(data_rdy), 1);
          chk(!prev_vld, "R7", "strobe isolated", longint'(prev_vld), 0);
        end
        strobes = 0;
        last_word = longint'(out_word);
        last_flag = ovr;
        hold_chk = 1'b1;
      end
      prev_vld = out_vld;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    finish_up();
  end

  initial begin
    repeat (4) step();
    // R9: reset state
    chk(out_vld == 1'b0, "R9", "reset out_vld", longint'(out_vld), 0);
    chk(data_rdy == 1'b0, "R9", "reset data_rdy", longint'(data_rdy), 0);
    chk(ovr == 1'b0, "R9", "reset ovr", longint'(ovr), 0);
    chk(out_word == '0, "R9", "reset out_word", longint'(out_word), 0);
    rst = 1'b0;
    step();

    // R4 R5: constant ones saturate high; constant zeros saturate low
    run(20, 64'h1, 1, 2, 1'b0);
    run(20, 64'h0, 1, 2, 1'b0);
    // R1: three-quarter density pattern 1,1,1,0
    run(20, 64'h7, 4, 3, 1'b0);
    // R1 R8: alternating pattern; code poked to 7 mid-run without restart
    run(20, 64'h1, 2, 3, 1'b1);
    // R5: headroom region flagged but not clipped (49 ones in 50)
    run(50, (64'd1 << 50) - 64'd2, 50, 2, 1'b0);
    // R2: code below minimum behaves as 19
    run(5, 64'h1, 1, 2, 1'b0);
    // R6: acknowledge clears data-ready
    chk(data_rdy == 1'b1, "R6", "data_rdy before ack", longint'(data_rdy), 1);
    rd_ack = 1'b1;
    step();
    rd_ack = 1'b0;
    chk(data_rdy == 1'b0, "R6", "data_rdy after ack", longint'(data_rdy), 0);
    // R3: restart mid-period discards history
    rate_code = 12'd20;
    restart = 1'b1;
    step();
    restart = 1'b0;
    repeat (8) step();
    for (int j = 0; j < 33; j++) begin
      bit_in = 1'b0;
      bit_vld = 1'b1;
      step();
      bit_vld = 1'b0;
      repeat (3) step();
    end
    run(40, 64'h3, 4, 2, 1'b0);
    // wide ratio exercises full accumulator width
    run(2000, 64'h1, 1, 1, 1'b0);
    finish_up();
  end
endmodule